// File: doc/BRIEF.md
# Stereo Sample Ring Buffer

This block is a circular queue of stereo audio samples placed between a processor and a serial audio port. Each entry pairs one 16-bit left sample with one 16-bit right sample. A producer pushes one pair per single-cycle pulse, and a consumer takes one pair per pulse. The oldest stored pair is always visible on the take outputs. It is built in two variants, selected by a parameter. In the output variant the processor is the producer and the audio port is the consumer. In the input variant the audio port produces and the processor consumes.

The number of active entries is set at run time as a power of two. The `size_log2` input gives the exponent. Both pointers are only as wide as the largest buffer, and they are masked down to the active size, so they wrap on their own. A five-state occupancy machine reports empty and full, and also drives the enable of the audio port. The five states are empty, one entry, in between, one slot left and full.

In the output variant, a push into a full buffer is dropped. The port enable is high only while data is queued. In the input variant the port enable is always high, and a push into a full buffer replaces the oldest pair.

Top module: `audio_sample_ring`

## Requirements
- R1: While reset is asserted and right after it, `empty`=1 and `full`=0.
- R2: Pairs leave in the order they entered. `take_left` and `take_right` show the oldest stored pair while `empty`=0, and the left and right halves stay together.
- R3: The active size is 2^`size_log2`. An exponent of 0 is treated as 1, and an exponent above `MAX_LOG` is treated as `MAX_LOG`. Starting from empty, `full` rises right after the size-th push and not before it.
- R4: A take while `empty`=1 changes nothing. The next pushed pair is the one that appears on the take outputs.
- R5: In the output variant (`IS_INPUT`=0), a push while `full`=1 is discarded. `full` stays 1 and the oldest pair stays on the outputs.
- R6: In the input variant (`IS_INPUT`=1), a push while `full`=1 stores the new pair and drops the oldest one. `full` stays 1, and the outputs move on to the next-oldest pair.
- R7: A push and a take in the same cycle, with the buffer neither empty nor full, leave `empty` and `full` unchanged.
- R8: With size 2, the flags follow the sequence push, push, take, take as (0,0), (0,1), (0,0), (1,0), given as (empty, full).
- R9: A change of the effective size empties the buffer within one cycle, and pushes or takes in that cycle are ignored.
- R10: `port_en` equals NOT `empty` in the output variant and is constantly 1 in the input variant.
- R11: `empty` and `full` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_log2 | input | LOG_W | Exponent of the active buffer size |
| put_en | input | 1 | Push pulse, one pair per cycle |
| put_left | input | 16 | Left sample to push |
| put_right | input | 16 | Right sample to push |
| take_en | input | 1 | Take pulse, removes the oldest pair |
| take_left | output | 16 | Left sample of the oldest pair |
| take_right | output | 16 | Right sample of the oldest pair |
| empty | output | 1 | No pair stored |
| full | output | 1 | Active size reached |
| port_en | output | 1 | Enable for the audio serial port |

## Verification
A wrong occupancy state shows at the ports within one cycle of the step that causes it. It appears as a flag that rises one push too early or too late, or as a take that returns a pair out of order. The tests with size 2 and size 4 exercise the one-entry and one-slot-left states, because those states are the only difference between "one more" and "full or empty". A pointer that moves on an ignored operation is caught by the next pair read out, which then differs from the queue model.

// File: rtl/audio_ring_pkg.sv
package audio_ring_pkg;
    localparam int SMP_W = 16;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } stereo_t;

    typedef enum logic [2:0] {
        OCC_EMPTY  = 3'd0,
        OCC_ONE    = 3'd1,
        OCC_MID    = 3'd2,
        OCC_ONELFT = 3'd3,
        OCC_FULL   = 3'd4
    } occ_e;
endpackage

// File: rtl/ring_sample_store.sv
module ring_sample_store
    import audio_ring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  stereo_t          wdata,
    input  logic [PTR_W-1:0] raddr,
    output stereo_t          rdata
);
    localparam int DEPTH = 1 << PTR_W;

    stereo_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ring_occupancy_fsm.sv
module ring_occupancy_fsm
    import audio_ring_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter int LOG_W    = 4,
    parameter bit IS_INPUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOG_W-1:0] size_log2,
    input  logic             put_req,
    input  logic             take_req,
    output logic             store_go,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr,
    output logic             is_empty,
    output logic             is_full
);
    typedef struct packed {
        occ_e             st;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LOG_W-1:0] lg;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [LOG_W-1:0] lg_eff;
    logic [PTR_W-1:0] mask;
    logic             size_chg, wr_ok, rd_ok, wr_only, rd_only, adv_rp, two;

    always_comb begin
        if (size_log2 == '0) begin
            lg_eff = LOG_W'(1);
        end else if (size_log2 > LOG_W'(PTR_W)) begin
            lg_eff = LOG_W'(PTR_W);
        end else begin
            lg_eff = size_log2;
        end
        size_chg = (lg_eff != ctl_q.lg);
        mask     = PTR_W'((32'd1 << ctl_q.lg) - 32'd1);
        two      = (ctl_q.lg == LOG_W'(1));
        rd_ok    = take_req && (ctl_q.st != OCC_EMPTY) && !size_chg;
        wr_ok    = put_req && ((ctl_q.st != OCC_FULL) || IS_INPUT) && !size_chg;
        wr_only  = wr_ok && !rd_ok;
        rd_only  = rd_ok && !wr_ok;
        adv_rp   = rd_ok || (wr_ok && (ctl_q.st == OCC_FULL));

        ctl_d = ctl_q;
        if (size_chg) begin
            ctl_d.st = OCC_EMPTY;
            ctl_d.wp = '0;
            ctl_d.rp = '0;
            ctl_d.lg = lg_eff;
        end else begin
            if (wr_ok)  ctl_d.wp = (ctl_q.wp + PTR_W'(1)) & mask;
            if (adv_rp) ctl_d.rp = (ctl_q.rp + PTR_W'(1)) & mask;
            unique case (ctl_q.st)
                OCC_EMPTY: if (wr_ok) ctl_d.st = OCC_ONE;
                OCC_ONE: begin
                    if (wr_only)      ctl_d.st = two ? OCC_FULL : OCC_MID;
                    else if (rd_only) ctl_d.st = OCC_EMPTY;
                end
                OCC_MID: begin
                    if (wr_only && (((ctl_q.wp + PTR_W'(2)) & mask) == ctl_q.rp))
                        ctl_d.st = OCC_ONELFT;
                    else if (rd_only && (((ctl_q.rp + PTR_W'(2)) & mask) == ctl_q.wp))
                        ctl_d.st = OCC_ONE;
                end
                OCC_ONELFT: begin
                    if (wr_only)      ctl_d.st = OCC_FULL;
                    else if (rd_only) ctl_d.st = OCC_MID;
                end
                OCC_FULL: if (rd_only) ctl_d.st = two ? OCC_ONE : OCC_ONELFT;
                default: ctl_d.st = OCC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st <= OCC_EMPTY;
            ctl_q.wp <= '0;
            ctl_q.rp <= '0;
            ctl_q.lg <= LOG_W'(PTR_W);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign store_go = wr_ok;
    assign wr_addr  = ctl_q.wp;
    assign rd_addr  = ctl_q.rp;
    assign is_empty = (ctl_q.st == OCC_EMPTY);
    assign is_full  = (ctl_q.st == OCC_FULL);

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_empty && is_full));

    p_empty_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty && take_req && !put_req |=> is_empty && $stable(ctl_q.rp));

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_full && !take_req && !size_chg |=> is_full);

    p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        IS_INPUT && is_full && put_req && !size_chg |=> is_full && (ctl_q.rp != $past(ctl_q.rp)));

    p_both_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_empty && !is_full && put_req && take_req && !size_chg |=> $stable(ctl_q.st));

    p_resize_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        size_chg |=> is_empty && (ctl_q.wp == '0) && (ctl_q.rp == '0));
endmodule

// File: rtl/audio_sample_ring.sv
module audio_sample_ring
    import audio_ring_pkg::*;
#(
    parameter int MAX_LOG  = 8,
    parameter bit IS_INPUT = 1'b0,
    localparam int LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOG_W-1:0] size_log2,
    input  logic             put_en,
    input  logic [SMP_W-1:0] put_left,
    input  logic [SMP_W-1:0] put_right,
    input  logic             take_en,
    output logic [SMP_W-1:0] take_left,
    output logic [SMP_W-1:0] take_right,
    output logic             empty,
    output logic             full,
    output logic             port_en
);
    logic               store_go;
    logic [MAX_LOG-1:0] wr_addr, rd_addr;
    stereo_t            wpair, rpair;

    assign wpair.left  = put_left;
    assign wpair.right = put_right;

    ring_occupancy_fsm #(
        .PTR_W(MAX_LOG), .LOG_W(LOG_W), .IS_INPUT(IS_INPUT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .size_log2(size_log2),
        .put_req(put_en), .take_req(take_en),
        .store_go(store_go), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .is_empty(empty), .is_full(full)
    );

    ring_sample_store #(.PTR_W(MAX_LOG)) u_store (
        .clk(clk), .we(store_go), .waddr(wr_addr), .wdata(wpair),
        .raddr(rd_addr), .rdata(rpair)
    );

    assign take_left  = rpair.left;
    assign take_right = rpair.right;

    generate
        if (IS_INPUT) begin : g_in
            assign port_en = 1'b1;
        end else begin : g_out
            assign port_en = !empty;
        end
    endgenerate
endmodule

// File: tb/sim_audio_sample_ring.sv
module sim_audio_sample_ring;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  size_log2 = 4'd2;
    logic        put_en = 1'b0, take_en = 1'b0;
    logic [15:0] put_left = '0, put_right = '0;
    logic [15:0] o_l, o_r, i_l, i_r;
    logic        o_e, o_f, o_pe, i_e, i_f, i_pe;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    audio_sample_ring #(.MAX_LOG(8), .IS_INPUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .size_log2(size_log2),
        .put_en(put_en), .put_left(put_left), .put_right(put_right),
        .take_en(take_en), .take_left(o_l), .take_right(o_r),
        .empty(o_e), .full(o_f), .port_en(o_pe));

    audio_sample_ring #(.MAX_LOG(8), .IS_INPUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .size_log2(size_log2),
        .put_en(put_en), .put_left(put_left), .put_right(put_right),
        .take_en(take_en), .take_left(i_l), .take_right(i_r),
        .empty(i_e), .full(i_f), .port_en(i_pe));

    // {put, take, value, exp_empty, exp_full, check_data, exp_value}; size 4
    localparam logic [36:0] VEC [16] = '{
        {1'b1,1'b0,16'h1111,1'b0,1'b0,1'b1,16'h1111},
        {1'b1,1'b0,16'h2222,1'b0,1'b0,1'b1,16'h1111},
        {1'b1,1'b0,16'h3333,1'b0,1'b0,1'b1,16'h1111},
        {1'b1,1'b0,16'h4444,1'b0,1'b1,1'b1,16'h1111},
        {1'b1,1'b0,16'h5555,1'b0,1'b1,1'b1,16'h1111},
        {1'b0,1'b1,16'h0000,1'b0,1'b0,1'b1,16'h2222},
        {1'b1,1'b1,16'h6666,1'b0,1'b0,1'b1,16'h3333},
        {1'b1,1'b0,16'h7777,1'b0,1'b1,1'b1,16'h3333},
        {1'b0,1'b1,16'h0000,1'b0,1'b0,1'b1,16'h4444},
        {1'b0,1'b1,16'h0000,1'b0,1'b0,1'b1,16'h6666},
        {1'b0,1'b1,16'h0000,1'b0,1'b0,1'b1,16'h7777},
        {1'b1,1'b1,16'h8888,1'b0,1'b0,1'b1,16'h8888},
        {1'b0,1'b1,16'h0000,1'b1,1'b0,1'b0,16'h0000},
        {1'b0,1'b1,16'h0000,1'b1,1'b0,1'b0,16'h0000},
        {1'b1,1'b0,16'h9999,1'b0,1'b0,1'b1,16'h9999},
        {1'b0,1'b1,16'h0000,1'b1,1'b0,1'b0,16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [15:0] v);
        @(negedge clk);
        put_en = w; take_en = r; put_left = v; put_right = ~v;
        @(posedge clk);
        #1;
        put_en = 1'b0; take_en = 1'b0;
    endtask

    task automatic resize(input logic [3:0] lg);
        @(negedge clk);
        size_log2 = lg;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 empty", {31'b0, o_e}, 32'd1);
        check("R1 full", {31'b0, o_f}, 32'd0);
        check("R10 out port_en", {31'b0, o_pe}, 32'd0);
        check("R10 in port_en", {31'b0, i_pe}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 empty after reset", {31'b0, o_e}, 32'd1);

        // R2 R4 R5 R7 table on the output variant, size 4
        for (int i = 0; i < 16; i++) begin
            logic [36:0] v;
            v = VEC[i];
            step(v[36], v[35], v[34:19]);
            check("R2/R4/R5/R7 empty", {31'b0, o_e}, {31'b0, v[18]});
            check("R2/R4/R5/R7 full", {31'b0, o_f}, {31'b0, v[17]});
            check("R10 port_en", {31'b0, o_pe}, {31'b0, ~v[18]});
            check("R11 exclusive", {31'b0, o_e & o_f}, 32'd0);
            if (v[16]) check("R2 pair", {o_l, o_r}, {v[15:0], ~v[15:0]});
        end

        // R8: size 2
        resize(4'd1);
        check("R9 cleared", {30'b0, o_e, i_e}, 32'd3);
        step(1'b1, 1'b0, 16'hA001);
        check("R8 one", {30'b0, o_e, o_f}, 32'd0);
        step(1'b1, 1'b0, 16'hA002);
        check("R8 full", {30'b0, o_e, o_f}, 32'd1);
        step(1'b0, 1'b1, 16'h0);
        check("R8 after take", {30'b0, o_e, o_f}, 32'd0);
        check("R8 data", {16'b0, o_l}, 32'hA002);
        step(1'b0, 1'b1, 16'h0);
        check("R8 empty", {30'b0, o_e, o_f}, 32'd2);

        // R6 and R5 side by side, size 2
        step(1'b1, 1'b0, 16'hB001);
        step(1'b1, 1'b0, 16'hB002);
        step(1'b1, 1'b0, 16'hB003);
        check("R6 full kept", {31'b0, i_f}, 32'd1);
        check("R6 oldest dropped", {i_l, i_r}, {16'hB002, ~16'hB002});
        check("R5 drop", {15'b0, o_f, o_l}, {15'b0, 1'b1, 16'hB001});
        step(1'b0, 1'b1, 16'h0);
        check("R6 next", {15'b0, i_f, i_l}, {15'b0, 1'b0, 16'hB003});
        step(1'b0, 1'b1, 16'h0);
        check("R6 drained", {31'b0, i_e}, 32'd1);
        check("R10 in port_en", {31'b0, i_pe}, 32'd1);

        // R3: exponent 0 is treated as 1
        resize(4'd0);
        step(1'b1, 1'b0, 16'hC001);
        check("R3 clamp low one", {31'b0, o_f}, 32'd0);
        step(1'b1, 1'b0, 16'hC002);
        check("R3 clamp low full", {31'b0, o_f}, 32'd1);

        // R3: largest size, 256
        resize(4'd8);
        for (int k = 0; k < 255; k++) step(1'b1, 1'b0, 16'(k));
        check("R3 255 not full", {31'b0, o_f}, 32'd0);
        step(1'b1, 1'b0, 16'd255);
        check("R3 256 full", {31'b0, o_f}, 32'd1);
        check("R2 oldest", {16'b0, o_l}, 32'd0);

        // R9: size change clears a full buffer
        resize(4'd3);
        check("R9 empty", {30'b0, o_e, o_f}, 32'd2);
        // R3: exponent above the maximum is treated as the maximum
        resize(4'd15);
        for (int k = 0; k < 255; k++) step(1'b1, 1'b0, 16'(k));
        check("R3 clamp high not full", {31'b0, o_f}, 32'd0);
        step(1'b1, 1'b0, 16'd255);
        check("R3 clamp high full", {31'b0, o_f}, 32'd1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule